// File: doc/BRIEF.md
# Line transfer and dot-inversion control

This block sits between the serial line latch of a column driver and its output stage. While the next line of grey codes is being shifted into the input latch, the output stage keeps driving the codes of the previous line from a separate holding register. A load strobe swaps the two. When the block sees the strobe high for the first time, it copies the whole input line into the holding register and captures a polarity select. The line does not need to be complete when the strobe arrives.

From the captured polarity the block derives one flag per output channel. The flag tells the output stage whether that channel uses the upper (positive) or the lower (negative) reference range. Neighbouring channels always get opposite ranges. Each strobe also starts a fixed-length settling count, which models the offset-cancellation period of the output amplifiers. The block reports the outputs as valid only when that count is complete. A timing guard watches the start pulse and the data-write indicator around the strobe and flags transfers that break the required spacing.

Top module: `line_xfer_ctrl`

## Requirements
- R1: The polarity select is sampled only on a strobe capture cycle and is kept until the next capture. Changes of `pol_i` at any other time have no effect on `pos_o`.
- R2: Channel numbers start at 1, and channel n is bit n-1 of `pos_o`. A flag value of 1 means the positive range. With captured polarity 1, the even-numbered channels are 1 and the odd-numbered channels are 0. With captured polarity 0 the pattern is inverted.
- R3: On a capture cycle, `held_o` takes the value that `line_i` has in that cycle, whatever the fill state of the line. At all other times `held_o` does not change.
- R4: The strobe is sampled synchronously. Only the first high sample of a high period is a capture cycle. Keeping the strobe high for more cycles copies nothing further.
- R5: After a capture at clock edge k, `valid_o` is low through edge k+SETTLE_CYC-1 and goes high at edge k+SETTLE_CYC (253 by default). It then stays high until the next capture.
- R6: A capture during the settling count, or after it, drops `valid_o` at the capture edge and starts the full count again from that edge.
- R7: If `start_i` is high in the capture cycle or in the cycle after it, `timing_err_o` is high for the one cycle after that sample. A start pulse two or more cycles after the capture raises no error.
- R8: If `data_wr_i` is high in the capture cycle, `timing_err_o` is high for the following cycle. A last write one cycle before the capture raises no error.
- R9: When reset is asserted, `held_o` is all zero, the captured polarity is 0 (so `pos_o` has 1 on the odd-numbered channels), and `valid_o` and `timing_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe |
| pol_i | input | 1 | Polarity select |
| start_i | input | 1 | Start pulse of the next line, used for timing checks |
| data_wr_i | input | 1 | High in any cycle in which a code is written into the input line |
| line_i | input | N_CH*CODE_W | Input line latch, channel c in bits [c*CODE_W +: CODE_W] |
| held_o | output | N_CH*CODE_W | Held codes driven to the output stage |
| pos_o | output | N_CH | Per-channel range flag, 1 = positive |
| valid_o | output | 1 | Outputs have settled |
| timing_err_o | output | 1 | Strobe spacing violation, one-cycle pulse |

## Verification
A wrong capture shows up on `held_o` and `pos_o` one edge after the strobe's first high sample. This covers a stale line, a second copy during a long strobe, and a polarity that leaks through between strobes. The bench compares the full line and every range flag in that cycle. A fault in the settling counter only appears at the end of the window. So the bench checks `valid_o` on both edge 252 and edge 253 after a capture, and repeats this after a restart in mid-count. An error in the guard window shows as a missing or extra one-cycle pulse on `timing_err_o`. The bench probes the window at offsets 0, 1 and 2.

// File: rtl/lxfer_pkg.sv
package lxfer_pkg;
  // idx is 0-based; channel number idx+1, even number -> positive when pol=1
  function automatic logic chan_positive(input logic pol, input int unsigned idx);
    logic even_num;
    even_num = ((idx + 1) % 2) == 0;
    return even_num ? pol : ~pol;
  endfunction
endpackage

// File: rtl/lxfer_strobe_det.sv
module lxfer_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic rise_o
);
  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= load_i;
  end

  assign rise_o = load_i & ~load_q;

  a_r4_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/lxfer_line_hold.sv
module lxfer_line_hold #(
  parameter int N_CH   = 48,
  parameter int CODE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic [N_CH*CODE_W-1:0]   line_i,
  output logic [N_CH*CODE_W-1:0]   held_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    code_q <= '0;
      else if (cap_i) code_q <= line_i[c*CODE_W +: CODE_W];
    end
    assign held_o[c*CODE_W +: CODE_W] = code_q;
  end

  a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(held_o));
  a_r3_hold_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (held_o == $past(line_i)));
endmodule

// File: rtl/lxfer_pol_map.sv
module lxfer_pol_map #(
  parameter int N_CH = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic            pol_i,
  output logic [N_CH-1:0] pos_o
);
  logic pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pol_q <= 1'b0;
    else if (cap_i) pol_q <= pol_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_map
    assign pos_o[c] = lxfer_pkg::chan_positive(pol_q, c);
  end

  a_r1_pol_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (pos_o[0] == !$past(pol_i)));
  a_r1_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(pos_o));
  a_r2_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && (pol_i != pol_q)) |=> (pos_o == ~$past(pos_o)));
endmodule

// File: rtl/lxfer_settle.sv
module lxfer_settle #(
  parameter int SETTLE_CYC = 253
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  output logic valid_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] rem_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      armed_q <= 1'b0;
    end else if (cap_i) begin
      rem_q   <= CW'(SETTLE_CYC);
      armed_q <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q   <= rem_q - 1'b1;
    end
  end

  assign valid_o = armed_q && (rem_q == '0);

  a_r6_cap_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> !valid_o);
  a_r5_valid_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(rem_q) == CW'(1)));
endmodule

// File: rtl/lxfer_guard.sv
module lxfer_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic start_i,
  input  logic data_wr_i,
  output logic err_o
);
  logic rise_q, err_q, viol;

  // start must wait two clocks after the capture; data must stop one clock before
  assign viol = (rise_i & (start_i | data_wr_i)) | (rise_q & start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rise_q <= rise_i;
      err_q  <= viol;
    end
  end

  assign err_o = err_q;

  a_r7_start_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && start_i) |=> err_o);
  a_r8_data_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && data_wr_i) |=> err_o);
endmodule

// File: rtl/line_xfer_ctrl.sv
module line_xfer_ctrl #(
  parameter int N_CH       = 48,
  parameter int CODE_W     = 8,
  parameter int SETTLE_CYC = 253
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   pol_i,
  input  logic                   start_i,
  input  logic                   data_wr_i,
  input  logic [N_CH*CODE_W-1:0] line_i,
  output logic [N_CH*CODE_W-1:0] held_o,
  output logic [N_CH-1:0]        pos_o,
  output logic                   valid_o,
  output logic                   timing_err_o
);
  logic cap;

  lxfer_strobe_det i_det (
    .clk_i, .rst_ni, .load_i, .rise_o(cap)
  );

  lxfer_line_hold #(.N_CH(N_CH), .CODE_W(CODE_W)) i_hold (
    .clk_i, .rst_ni, .cap_i(cap), .line_i, .held_o
  );

  lxfer_pol_map #(.N_CH(N_CH)) i_pol (
    .clk_i, .rst_ni, .cap_i(cap), .pol_i, .pos_o
  );

  lxfer_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i, .rst_ni, .cap_i(cap), .valid_o
  );

  lxfer_guard i_guard (
    .clk_i, .rst_ni, .rise_i(cap), .start_i, .data_wr_i, .err_o(timing_err_o)
  );

  a_r9_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && !timing_err_o));
endmodule

// File: tb/test_line_xfer_ctrl.sv
`timescale 1ns/1ps
module test_line_xfer_ctrl;
  localparam int N = 48, W = 8, S = 253;
  localparam int LW = N * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0, pol = 0, start = 0, dwr = 0;
  logic [LW-1:0] line = '0;
  logic [LW-1:0] held;
  logic [N-1:0]  pos;
  logic          valid, err;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  line_xfer_ctrl #(.N_CH(N), .CODE_W(W), .SETTLE_CYC(S)) i_line_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .pol_i(pol), .start_i(start),
    .data_wr_i(dwr), .line_i(line), .held_o(held), .pos_o(pos),
    .valid_o(valid), .timing_err_o(err)
  );

  function automatic logic [N-1:0] exp_pos(input logic p);
    logic [N-1:0] v;
    for (int c = 0; c < N; c++) v[c] = ((c + 1) % 2 == 0) ? p : ~p;
    return v;
  endfunction

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] v;
    for (int i = 0; i < LW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rise(input logic p, input logic [LW-1:0] ln, input logic st, input logic dw);
    load = 1; pol = p; line = ln; start = st; dwr = dw;
    tick();
    start = 0; dwr = 0;
  endtask

  task automatic drop();
    load = 0; tick();
  endtask

  initial begin
    logic [LW-1:0] a, b;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1; tick();
    // R9 reset state
    chk("R9 held", held, '0);
    chk("R9 pos", pos, exp_pos(1'b0));
    chk("R9 valid", valid, 0);
    chk("R9 err", err, 0);

    // R3/R2/R4/R5 directed
    for (int c = 0; c < N; c++) a[c*W +: W] = W'(c + 1);
    b = ~a;
    rise(1'b1, a, 0, 0);             // edge k
    chk("R3 copy", held, a);
    chk("R2 pol1 map", pos, exp_pos(1'b1));
    chk("R5 valid low at capture", valid, 0);
    line = b; tick();                // k+1, strobe still high
    chk("R4 no second copy", held, a);
    load = 0;
    for (int n = 2; n <= S; n++) begin
      tick();
      if (n == S - 1) chk("R5 valid low at 252", valid, 0);
      if (n == S)     chk("R5 valid high at 253", valid, 1);
    end

    // R1 polarity change without strobe ignored
    pol = 0; line = rand_line(); tick(); tick();
    chk("R1 pol ignored", pos, exp_pos(1'b1));
    chk("R3 held ignored", held, a);
    chk("R5 valid stays", valid, 1);

    // R6 restart
    a = rand_line();
    rise(1'b0, a, 0, 0);
    chk("R6 valid drop", valid, 0);
    chk("R2 pol0 map", pos, exp_pos(1'b0));
    chk("R3 copy 2", held, a);
    drop();
    repeat (98) tick();
    b = rand_line();
    rise(1'b1, b, 0, 0);
    chk("R6 restart copy", held, b);
    load = 0;
    for (int n = 1; n <= S; n++) begin
      tick();
      if (n == S - 1) chk("R6 still low at 252 after restart", valid, 0);
      if (n == S)     chk("R6 high at 253 after restart", valid, 1);
    end

    // R7 start spacing
    rise(1'b0, a, 1, 0);
    chk("R7 start at capture", err, 1);
    tick();
    chk("R7 pulse ends", err, 0);
    drop();
    rise(1'b0, a, 0, 0);
    chk("R7 no err yet", err, 0);
    start = 1; tick(); start = 0;
    chk("R7 start one after", err, 1);
    drop(); drop();
    rise(1'b1, a, 0, 0);
    tick();
    start = 1; tick(); start = 0;
    chk("R7 start two after ok", err, 0);
    drop();

    // R8 data spacing
    rise(1'b1, b, 0, 1);
    chk("R8 data at capture", err, 1);
    drop(); drop();
    dwr = 1; tick(); dwr = 0;
    rise(1'b0, a, 0, 0);
    chk("R8 data one before ok", err, 0);
    drop();

    // random captures
    for (int i = 0; i < 12; i++) begin
      logic p;
      p = 1'($urandom);
      a = rand_line();
      rise(p, a, 0, 0);
      chk("R3 rand copy", held, a);
      chk("R2 rand map", pos, exp_pos(p));
      line = rand_line(); pol = ~p;
      repeat (1 + $urandom % 3) tick();
      chk("R4 rand long strobe", held, a);
      drop();
      repeat ($urandom % 4) tick();
      chk("R1 rand hold", pos, exp_pos(p));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule